// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Access Sequencer

This block sits between a simple host request port and a fast-page-mode DRAM. Each host request carries a word address, a read/write flag and, for writes, one data nibble. The block splits the address into a row part and a column part. It then produces the strobe sequence the DRAM expects: the row is activated with RAS#, each word is accessed with a CAS# pulse, and RAS# is precharged before a different row can be opened.

The row stays open after an access. A later request that hits the same row costs only a column cycle. A request to another row first raises RAS# for the precharge time and then activates the new row. Writes are always issued as early writes, with WE# low before CAS# falls, so the DRAM never drives the data pins while a write is in progress. Reads keep WE# high and enable the DRAM outputs with OE#. The read nibble is sampled at the end of the CAS# low window and handed back with a single-cycle valid pulse.

A separate refresh block asks for the memory through a request/grant/done handshake. When it does, the sequencer finishes the access in progress, closes the page at the next request boundary, and releases all strobes while the grant is held. All strobe phase lengths are parameter counts of controller clocks.

Top module: `fpm_seq`

## Requirements
- R1: Row activation puts address bits [21:10] on `dram_addr` when RAS# falls. Each column cycle puts address bits [9:0] on `dram_addr` when CAS# falls.
- R2: While a row is open, a request whose address bits [21:10] equal the open row is served with a CAS# cycle only. RAS# stays low and no new activation happens.
- R3: A request to a different row while a page is open raises RAS#, keeps it high for at least `T_RP` clocks, and then activates the requested row. Every RAS# low edge is preceded by at least `T_RP` clocks of RAS# high.
- R4: CAS# falls no earlier than `T_RCD` clocks after the RAS# low edge that opened the row.
- R5: A write drives WE# low at least one clock before CAS# falls, keeps OE# high and the data-bus enable high while CAS# is low, and stores the request's nibble at the addressed word.
- R6: A read keeps WE# high and the data-bus enable low, and drives OE# low while CAS# is low. It returns the addressed nibble on `rsp_rdata` with `rsp_valid` high for exactly one clock.
- R7: While `ref_req` is high, `req_ready` is low. The page is closed before `ref_grant` rises. RAS# and CAS# stay high while `ref_grant` is high. After `ref_done`, the next access activates its row again.
- R8: After reset, all DRAM strobes are high, the data-bus enable is low, `rsp_valid` is low and `req_ready` is high.
- R9: Each CAS# low pulse lasts at least `T_CAS` clocks. Between two CAS# pulses inside one page, CAS# stays high for at least `T_CP` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in [21:10], column in [9:0] |
| req_wdata | input | 4 | Write nibble |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 4 | Read nibble |
| ref_req | input | 1 | Refresh block asks for the memory |
| ref_grant | output | 1 | Memory handed to the refresh block |
| ref_done | input | 1 | Refresh block hands the memory back |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_oe | output | 1 | Controller drives the data pins |
| dram_dq_out | output | 4 | Data driven to the DRAM |
| dram_dq_in | input | 4 | Data read from the DRAM |

## Verification
The bench writes a grid of words whose rows include 0 and 4095 and whose columns include 0 and 1023. It visits the columns in an order that makes every write a row miss, then reads the grid back row by row so that most reads are page hits. A design that reopened the row on a hit would show extra activations. One that skipped the precharge on a miss would write into the wrong row or break the RAS# high time. A behavioural DRAM model in the bench enforces strobe ordering on every edge. A late WE# would appear as a WE# fall inside the CAS# low window, and a misplaced column would corrupt the data read back. The refresh handover is exercised with a page left open, which catches a grant given while RAS# is still low and a stale open-row record that skips the reactivation.

// File: rtl/fpm_pkg.sv
// Shared types for the fast-page-mode sequencer.
// Assumes: one state register in the top module uses this encoding.
package fpm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,   // no row open, RAS# high
        S_ACT,    // RAS# low with row address, waiting row-to-column delay
        S_OPEN,   // row open, waiting for the next request
        S_COLS,   // column address and WE# set up, CAS# still high
        S_CASL,   // CAS# low
        S_CP,     // CAS# high precharge inside the page
        S_PRE,    // RAS# high precharge
        S_GRANT   // memory handed to the refresh block
    } fpm_state_e;
endpackage

// File: rtl/fpm_timer.sv
// Down-counter that times one strobe phase.
// Assumes: load is pulsed on entry to a phase with (length - 1); expired
// is high on the last clock of the phase.
module fpm_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fpm_row_track.sv
// Remembers which row is open and compares an incoming row against it.
// Assumes: set and clear are never high together.
module fpm_row_track #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clear,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    // Record the row on activation and forget it on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (set) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end else if (clear) begin
            open_q <= 1'b0;
        end
    end

    assign hit = open_q && (row_q == cmp_row);
endmodule

// File: rtl/fpm_seq.sv
// Fast-page-mode DRAM access sequencer (top).
// Turns host requests into RAS#/CAS#/WE#/OE# sequences. It keeps the row
// open for same-row hits, precharges on a miss, always uses early write,
// and hands the memory to a refresh block at request boundaries.
// Assumes: every T_* parameter is at least 1.
module fpm_seq #(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DATA_W = 4,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_CP   = 1,
    parameter int T_RP   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic                     ref_req,
    output logic                     ref_grant,
    input  logic                     ref_done,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic                     dram_dq_oe,
    output logic [DATA_W-1:0]        dram_dq_out,
    input  logic [DATA_W-1:0]        dram_dq_in
);
    import fpm_pkg::*;

    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int DRAM_AW = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_MAX1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_MAX2  = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int T_MAX   = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int CNT_W   = (T_MAX < 2) ? 1 : $clog2(T_MAX);
    localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] L_CP  = CNT_W'(T_CP - 1);
    localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);

    fpm_state_e          state_q, state_d;
    logic                wr_q, pend_q;
    logic [ROW_W-1:0]    row_q;
    logic [COL_W-1:0]    col_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                accept, expired, hit_w, t_load;
    logic [CNT_W-1:0]    t_val;
    logic [ROW_W-1:0]    req_row;
    logic [COL_W-1:0]    req_col;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];
    assign req_ready = ((state_q == S_IDLE) || (state_q == S_OPEN)) && !ref_req;
    assign accept    = req_valid && req_ready;

    fpm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(expired)
    );

    fpm_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .set(state_q == S_ACT), .clear(state_q == S_PRE),
        .set_row(row_q), .cmp_row(req_row), .hit(hit_w)
    );

    // Next-state selection for the strobe sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (ref_req) state_d = S_GRANT;
                     else if (req_valid) state_d = S_ACT;
            S_ACT:   if (expired) state_d = S_COLS;
            S_OPEN:  if (ref_req) state_d = S_PRE;
                     else if (req_valid) state_d = hit_w ? S_COLS : S_PRE;
            S_COLS:  state_d = S_CASL;
            S_CASL:  if (expired) state_d = S_CP;
            S_CP:    if (expired) state_d = S_OPEN;
            S_PRE:   if (expired) state_d = pend_q ? S_ACT : S_IDLE;
            S_GRANT: if (ref_done) state_d = S_PRE;
            default: state_d = S_IDLE;
        endcase
    end

    // Phase length loaded into the timer on entry to a timed state.
    always_comb begin
        t_load = (state_d != state_q);
        unique case (state_d)
            S_ACT:   t_val = L_RCD;
            S_CASL:  t_val = L_CAS;
            S_CP:    t_val = L_CP;
            S_PRE:   t_val = L_RP;
            default: t_val = '0;
        endcase
    end

    // State register and accepted-request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wr_q    <= 1'b0;
            pend_q  <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wr_q    <= req_write;
                row_q   <= req_row;
                col_q   <= req_col;
                wdata_q <= req_wdata;
                pend_q  <= (state_q == S_OPEN) && !hit_w;
            end else if (state_q == S_PRE && expired) begin
                pend_q  <= 1'b0;
            end
        end
    end

    // Read capture at the end of the CAS# low window, one-clock response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state_q == S_CASL) && expired && !wr_q;
            if ((state_q == S_CASL) && expired && !wr_q)
                rsp_rdata <= dram_dq_in;
        end
    end

    // Strobe and address decode from the current phase.
    always_comb begin
        dram_ras_n  = !((state_q == S_ACT) || (state_q == S_OPEN) || (state_q == S_COLS)
                        || (state_q == S_CASL) || (state_q == S_CP));
        dram_cas_n  = (state_q != S_CASL);
        dram_we_n   = !(((state_q == S_COLS) || (state_q == S_CASL)) && wr_q);
        dram_oe_n   = !((state_q == S_CASL) && !wr_q);
        dram_dq_oe  = ((state_q == S_COLS) || (state_q == S_CASL)) && wr_q;
        dram_dq_out = wdata_q;
        ref_grant   = (state_q == S_GRANT);
        if (state_q == S_ACT)
            dram_addr = DRAM_AW'(row_q);
        else if ((state_q == S_COLS) || (state_q == S_CASL) || (state_q == S_CP))
            dram_addr = DRAM_AW'(col_q);
        else
            dram_addr = '0;
    end

    // R5: WE# is already low on the clock before CAS# falls for a write.
    a_r5_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));
    // R5: DRAM outputs never enabled while WE# is low.
    a_r5_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);
    // R6: read response lasts one clock.
    a_r6_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R7: strobes released and host stalled while refresh holds the memory.
    a_r7_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> (dram_ras_n && dram_cas_n && !req_ready));
    // R4: CAS# never falls in the same clock as RAS#.
    a_r4_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> dram_cas_n);
    // R2: an accepted same-row request keeps RAS# low.
    a_r2_hit_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPEN && accept && hit_w) |=> !dram_ras_n);
endmodule

// File: tb/fpm_seq_tb.sv
// Bench for fpm_seq: behavioural DRAM model, strobe-timing monitor and
// grid sweep with arithmetic expected data.
module fpm_seq_tb;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0, ref_done = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_wdata = '0, dram_dq_in = '0;
    logic req_ready, rsp_valid, ref_grant, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  rsp_rdata, dram_dq_out;
    logic [11:0] dram_addr;

    fpm_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req),
        .ref_grant(ref_grant), .ref_done(ref_done), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out),
        .dram_dq_in(dram_dq_in));

    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0, act_cnt = 0, cycles = 0;
    logic [11:0] exp_row = '0;
    logic [9:0]  exp_col = '0;
    logic [3:0]  mem [int];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // DRAM model and strobe-timing monitor, sampled mid-cycle.
    logic [11:0] cur_row = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, first_cas = 1'b0;
    int ras_hi = 100, cas_hi = 100, cas_lo = 0, rcd = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n && prev_ras) begin
                act_cnt++;
                check(ras_hi >= T_RP, "R3 RAS high time", ras_hi, T_RP);
                check(dram_addr == exp_row, "R1 row address", dram_addr, exp_row);
                cur_row = dram_addr; rcd = 0; first_cas = 1'b1; cas_hi = 100;
            end
            if (!dram_cas_n && prev_cas) begin
                if (first_cas) check(rcd >= T_RCD, "R4 RAS to CAS", rcd, T_RCD);
                first_cas = 1'b0;
                check(cas_hi >= T_CP, "R9 CAS high time", cas_hi, T_CP);
                check(dram_addr[9:0] == exp_col, "R1 column address", dram_addr, exp_col);
                if (!dram_we_n) begin
                    check(!prev_we, "R5 early WE", prev_we, 0);
                    check(dram_dq_oe, "R5 bus enable", dram_dq_oe, 1);
                    mem[int'({cur_row, dram_addr[9:0]})] = dram_dq_out;
                end
            end
            if (dram_cas_n && !prev_cas) check(cas_lo >= T_CAS, "R9 CAS low time", cas_lo, T_CAS);
            if (!dram_cas_n && !dram_we_n) check(dram_oe_n, "R5 OE high in write", dram_oe_n, 1);
            if (!dram_cas_n && dram_we_n)
                check(!dram_oe_n && !dram_dq_oe, "R6 read pins", {dram_oe_n, dram_dq_oe}, 0);
            if (ref_req) check(!req_ready, "R7 ready low", req_ready, 0);
            if (ref_grant) check(dram_ras_n && dram_cas_n, "R7 strobes idle", {dram_ras_n, dram_cas_n}, 3);
            ras_hi = dram_ras_n ? ras_hi + 1 : 0;
            cas_hi = dram_cas_n ? cas_hi + 1 : 0;
            cas_lo = dram_cas_n ? 0 : cas_lo + 1;
            if (!dram_ras_n) rcd++;
            prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
            dram_dq_in = (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
                ? (mem.exists(int'({cur_row, dram_addr[9:0]})) ? mem[int'({cur_row, dram_addr[9:0]})] : 4'h0)
                : 4'h0;
        end
    end

    function automatic logic [11:0] row_of(int i);
        return (i == 3) ? 12'hFFF : (i == 2) ? 12'hA5C : 12'(i);
    endfunction
    function automatic logic [9:0] col_of(int j);
        return (j >= 6) ? 10'(1016 + j) : 10'(j);
    endfunction
    function automatic logic [3:0] pat(int i, int j);
        return 4'((i * 3 + j * 5 + 1) & 15);
    endfunction

    task automatic host(input bit w, input logic [11:0] r, input logic [9:0] c,
                        input logic [3:0] d, input logic [3:0] exp_d, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_row = r; exp_col = c;
        req_valid = 1'b1; req_write = w; req_addr = {r, c}; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (!w) begin
            while (!rsp_valid) @(negedge clk);
            check(rsp_rdata == exp_d, tag, rsp_rdata, exp_d);
            @(negedge clk);
            check(!rsp_valid, "R6 single pulse", rsp_valid, 0);
        end
    endtask

    bit done = 1'b0;
    initial begin
        int a0;
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid,
              "R8 strobes after reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R8 ready after reset", req_ready, 1);
        // Writes column-major: every write changes row (R3, R5).
        a0 = act_cnt;
        for (int j = 0; j < 8; j++)
            for (int i = 0; i < 4; i++)
                host(1'b1, row_of(i), col_of(j), pat(i, j), 4'h0, "R5");
        @(negedge clk); while (!req_ready) @(negedge clk);
        check(act_cnt - a0 == 32, "R3 activations on misses", act_cnt - a0, 32);
        // Reads row-major: one activation per row, rest are hits (R2, R6).
        a0 = act_cnt;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 8; j++)
                host(1'b0, row_of(i), col_of(j), 4'h0, pat(i, j), "R6 read data");
        check(act_cnt - a0 == 4, "R2 activations on hits", act_cnt - a0, 4);
        // Refresh with a page open (R7).
        host(1'b0, row_of(0), col_of(0), 4'h0, pat(0, 0), "R6 read data");
        a0 = act_cnt;
        @(negedge clk);
        ref_req = 1'b1;
        while (!ref_grant) @(negedge clk);
        check(dram_ras_n, "R7 page closed at grant", dram_ras_n, 1);
        repeat (3) @(negedge clk);
        ref_req = 1'b0; ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;
        host(1'b0, row_of(0), col_of(1), 4'h0, pat(0, 1), "R7 read after refresh");
        host(1'b0, row_of(0), col_of(7), 4'h0, pat(0, 7), "R2 hit after refresh");
        check(act_cnt - a0 == 1, "R7 reactivation after refresh", act_cnt - a0, 1);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) check(1'b0, "watchdog", cycles, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule